// File: doc/BRIEF.md
# Linked-List 2D DMA Descriptor Engine

A single-channel transfer engine that walks a chain of eight-word descriptors held in a small local descriptor store and moves data between a word-wide memory port and a peripheral port. Each descriptor selects the transfer direction, the peripheral unit width (8, 16 or 32 bits), an optional byte reversal, a peripheral address with an optional step, the memory start address with extended upper bits, a beat count or a two-dimensional row/stride shape, a burst size with a fixed pause between bursts, and a link to the next descriptor.

Software fills the descriptor store through a write port, then pulses `start` with the byte address of the first descriptor. The engine fetches the eight words, runs the beats one unit at a time (source access, then destination access), follows the link until a descriptor marked final, and reports complete. A programmable watchdog ends a stalled transfer with a timeout status. Complete and timeout are held until software acknowledges them, and a one-cycle interrupt pulse marks entry to either.

Top module: `dll_dma_engine`

## Requirements
- R1: After reset the status is idle (code 0), no request is raised on either port and the interrupt is low.
- R2: A start pulse is accepted only while the status is idle; a start during a busy, complete (code 2) or timeout (code 3) status has no effect.
- R3: Descriptor word layout: w0 bit0 swap, bit1 direction, bits3:2 width; w1 bit0 step enable, bits2:1 step code, bits31:16 beat count; w2 peripheral address; w3 bits2:0 delay code, bits6:4 burst code, bits 8 upward extended memory bits; w4 bit0 2D enable, bits31:16 row count; w5 bits15:0 row bytes, bits31:16 line gap; w6 memory byte address; w7 bits27:0 link, bit31 final. With direction 0 the engine reads memory and writes the peripheral, one unit per beat, memory address advancing by the unit size, and never requests both ports in one cycle.
- R4: Width code 0 moves 4 bytes, 1 moves 2 bytes, 2 or 3 moves 1 byte; a memory beat uses byte lanes starting at address bits 1:0, while peripheral data sits right-aligned.
- R5: Swap bit 1 reverses the byte order inside each moved unit (no change for 1-byte units); swap bit 0 passes bytes unchanged.
- R6: With step enable 1 the peripheral address advances per beat by 4, 2 or 1 for step code 0, 1, 2 (or 3); with step enable 0 it stays fixed.
- R7: With 2D enabled the beat count field is ignored; the engine moves row-count rows of row-bytes each and adds the line gap to the memory address after every row.
- R8: After each burst of (burst code + 1) beats, when more beats remain, the engine pauses delay code × DELAY_STEP cycles with no request before the next beat.
- R9: After a descriptor whose final bit is set (or whose link is zero) the engine completes; otherwise it fetches the next descriptor at the link, used as a byte address when `list_sys` is 0 and shifted left by 4 when `list_sys` is 1.
- R10: Complete (code 2) and timeout (code 3) are held until a `status_rd` pulse, which returns the status to idle; busy is code 1.
- R11: With a non-zero `wd_limit`, a transfer whose port access is not granted for more than `wd_limit` consecutive cycles ends in timeout; the count restarts on each granted access.
- R12: `irq` is a one-cycle pulse on entry to complete or timeout, one pulse per chain.
- R13: A `cancel` pulse returns the status to idle in the next cycle and drops all requests, from any state, without an interrupt.
- R14: With direction 1 the engine reads the peripheral and writes memory with byte enables for the unit's lanes, the memory address carrying the descriptor's extended bits above bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| list_sys | input | 1 | 1: links are stored shifted right by 4 |
| start | input | 1 | Start pulse |
| start_ptr | input | 32 | Byte address of the first descriptor |
| status_rd | input | 1 | Status acknowledge pulse |
| cancel | input | 1 | Abandon any transfer and go idle |
| wd_limit | input | WD_W | Watchdog stall limit, 0 disables |
| dsc_we | input | 1 | Descriptor store write enable |
| dsc_addr | input | log2(DESC_WORDS) | Descriptor store word index |
| dsc_wdata | input | 32 | Descriptor store write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | 32+EXT_W | Memory byte address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with grant |
| mem_gnt | input | 1 | Memory grant |
| per_req | output | 1 | Peripheral access request |
| per_we | output | 1 | Peripheral write (else read) |
| per_addr | output | 32 | Peripheral address |
| per_wdata | output | 32 | Peripheral write data, right-aligned |
| per_rdata | input | 32 | Peripheral read data, valid with grant |
| per_gnt | input | 1 | Peripheral grant |
| status | output | 2 | 0 idle, 1 busy, 2 complete, 3 timeout |
| irq | output | 1 | Completion/timeout pulse |

## Verification
The assertions watch on every cycle that no request is raised while idle or pausing, that only one port is requested at a time, that a held completion stays until acknowledged, that a watchdog expiry leads straight to timeout, that cancel lands in idle and that the interrupt is a single pulse tied to an end state. Lane placement, byte reversal, peripheral stepping, the 2D row and gap arithmetic, the link interpretation in both list locations and the exact pause length between bursts can only be shown by the bench's scenarios, which predict every destination write and compare it as it appears.

// File: rtl/dll_pkg.sv
package dll_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_FETCH, S_SETUP, S_SRC, S_DST, S_PAUSE, S_NEXT, S_CPL, S_TMO
   } eng_state_e;

   localparam logic [1:0] STAT_IDLE = 2'd0;
   localparam logic [1:0] STAT_BUSY = 2'd1;
   localparam logic [1:0] STAT_CPL  = 2'd2;
   localparam logic [1:0] STAT_TMO  = 2'd3;

   // bytes moved per beat for a width code
   function automatic logic [2:0] unit_bytes(input logic [1:0] pw);
      case (pw)
         2'd0:    return 3'd4;
         2'd1:    return 3'd2;
         default: return 3'd1;
      endcase
   endfunction

   function automatic logic [31:0] unit_mask(input logic [1:0] pw);
      case (pw)
         2'd0:    return 32'hFFFF_FFFF;
         2'd1:    return 32'h0000_FFFF;
         default: return 32'h0000_00FF;
      endcase
   endfunction

   function automatic logic [1:0] unit_shift(input logic [1:0] pw);
      case (pw)
         2'd0:    return 2'd2;
         2'd1:    return 2'd1;
         default: return 2'd0;
      endcase
   endfunction

   // reverse bytes inside a right-aligned unit
   function automatic logic [31:0] swap_unit(input logic [31:0] d, input logic [1:0] pw);
      logic [31:0] r;
      r = {d[7:0], d[15:8], d[23:16], d[31:24]};
      case (pw)
         2'd0:    return r;
         2'd1:    return r >> 16;
         default: return d;
      endcase
   endfunction

endpackage

// File: rtl/dll_desc_mem.sv
module dll_desc_mem #(
   parameter int DEPTH = 64,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [31:0]   wdata,
   input  logic [AW-1:0] raddr,
   output logic [31:0]   rdata
);
   logic [31:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/dll_lane.sv
module dll_lane
   import dll_pkg::*;
#(
   parameter bit SWAP_EN = 1'b1
) (
   input  logic [1:0]  pw,
   input  logic        swap,
   input  logic [1:0]  lane,
   input  logic        from_mem,
   input  logic [31:0] mem_word,
   input  logic [31:0] per_word,
   input  logic [31:0] unit_in,
   output logic [31:0] unit_out,
   output logic [31:0] wr_word,
   output logic [3:0]  be
);
   logic [31:0] raw, masked;
   logic [3:0]  be_base;

   assign raw    = from_mem ? (mem_word >> {lane, 3'b000}) : per_word;
   assign masked = raw & unit_mask(pw);

   generate
      if (SWAP_EN) begin : g_swap
         assign unit_out = swap ? swap_unit(masked, pw) : masked;
      end else begin : g_noswap
         logic unused_swap;
         assign unused_swap = swap;
         assign unit_out    = masked;
      end
   endgenerate

   always_comb begin
      case (pw)
         2'd0:    be_base = 4'hF;
         2'd1:    be_base = 4'h3;
         default: be_base = 4'h1;
      endcase
   end

   assign be      = be_base << lane;
   assign wr_word = unit_in << {lane, 3'b000};
endmodule

// File: rtl/dll_watchdog.sv
module dll_watchdog #(
   parameter int WD_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   input  logic            gnt,
   input  logic [WD_W-1:0] limit,
   output logic            expired
);
   logic [WD_W-1:0] cnt;

   assign expired = active && !gnt && (limit != '0) && (cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (!active || gnt)   cnt <= '0;
      else if (!expired)         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/dll_dma_engine.sv
module dll_dma_engine
   import dll_pkg::*;
#(
   parameter int DESC_WORDS = 64,
   parameter int EXT_W      = 4,
   parameter int DELAY_STEP = 256,
   parameter int WD_W       = 16,
   parameter bit SWAP_EN    = 1'b1,
   localparam int IW   = $clog2(DESC_WORDS),
   localparam int MA_W = 32 + EXT_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            list_sys,
   input  logic            start,
   input  logic [31:0]     start_ptr,
   input  logic            status_rd,
   input  logic            cancel,
   input  logic [WD_W-1:0] wd_limit,
   input  logic            dsc_we,
   input  logic [IW-1:0]   dsc_addr,
   input  logic [31:0]     dsc_wdata,
   output logic            mem_req,
   output logic            mem_we,
   output logic [MA_W-1:0] mem_addr,
   output logic [3:0]      mem_be,
   output logic [31:0]     mem_wdata,
   input  logic [31:0]     mem_rdata,
   input  logic            mem_gnt,
   output logic            per_req,
   output logic            per_we,
   output logic [31:0]     per_addr,
   output logic [31:0]     per_wdata,
   input  logic [31:0]     per_rdata,
   input  logic            per_gnt,
   output logic [1:0]      status,
   output logic            irq
);
   localparam int DLY_W = $clog2(7 * DELAY_STEP + 1);

   generate
      if (DESC_WORDS < 8 || (DESC_WORDS & (DESC_WORDS - 1)) != 0) begin : g_bad_depth
         $error("DESC_WORDS must be a power of two of at least 8");
      end
      if (EXT_W < 1 || EXT_W > 8) begin : g_bad_ext
         $error("EXT_W must lie in 1..8");
      end
      if (DELAY_STEP < 1) begin : g_bad_step
         $error("DELAY_STEP must be positive");
      end
   endgenerate

   eng_state_e       st;
   logic [IW-1:0]    base;
   logic [2:0]       fcnt;
   logic [31:0]      dw [8];
   logic [31:0]      rd_word;
   logic [31:0]      maddr, paddr, hold;
   logic [15:0]      beats_left, rb_reload, rows_left;
   logic [2:0]       bcnt;
   logic [DLY_W-1:0] dly;

   // descriptor store
   dll_desc_mem #(.DEPTH(DESC_WORDS)) u_store (
      .clk(clk), .we(dsc_we), .waddr(dsc_addr), .wdata(dsc_wdata),
      .raddr(base + IW'(fcnt)), .rdata(rd_word)
   );

   genvar g;
   generate
      for (g = 0; g < 8; g++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   dw[g] <= '0;
            else if (st == S_FETCH && fcnt == 3'(g))      dw[g] <= rd_word;
         end
      end
   endgenerate

   // field decode
   logic             f_swap, f_dir, f_pinc, f_2d, f_fin;
   logic [1:0]       f_pw, f_pstep;
   logic [2:0]       f_dly, f_burst;
   logic [EXT_W-1:0] f_ext;
   logic [15:0]      f_len, f_rep, f_rowb, f_gap;
   logic [27:0]      f_link;

   assign f_swap  = dw[0][0];
   assign f_dir   = dw[0][1];
   assign f_pw    = dw[0][3:2];
   assign f_pinc  = dw[1][0];
   assign f_pstep = dw[1][2:1];
   assign f_len   = dw[1][31:16];
   assign f_dly   = dw[3][2:0];
   assign f_burst = dw[3][6:4];
   assign f_ext   = dw[3][8 +: EXT_W];
   assign f_2d    = dw[4][0];
   assign f_rep   = dw[4][31:16];
   assign f_rowb  = dw[5][15:0];
   assign f_gap   = dw[5][31:16];
   assign f_link  = dw[7][27:0];
   assign f_fin   = dw[7][31];

   logic [2:0]       ub;
   logic [31:0]      pstep_v, link_byte;
   logic [15:0]      rb_calc, rows_calc;
   logic [DLY_W-1:0] dly_load;
   logic             stop_here;

   assign ub        = unit_bytes(f_pw);
   assign pstep_v   = !f_pinc ? 32'd0 : (f_pstep == 2'd0) ? 32'd4 : (f_pstep == 2'd1) ? 32'd2 : 32'd1;
   assign rb_calc   = f_2d ? (f_rowb >> unit_shift(f_pw)) : f_len;
   assign rows_calc = f_2d ? f_rep : 16'd1;
   assign link_byte = list_sys ? {f_link, 4'b0000} : {4'b0000, f_link};
   assign stop_here = f_fin || (f_link == '0);
   assign dly_load  = DLY_W'({29'd0, f_dly} * DELAY_STEP - 1);

   // byte lanes
   logic [31:0] unit_x, wr_word;
   logic [3:0]  be_x;

   dll_lane #(.SWAP_EN(SWAP_EN)) u_lane (
      .pw(f_pw), .swap(f_swap), .lane(maddr[1:0]), .from_mem(!f_dir),
      .mem_word(mem_rdata), .per_word(per_rdata), .unit_in(hold),
      .unit_out(unit_x), .wr_word(wr_word), .be(be_x)
   );

   // ports
   logic src_gnt, dst_gnt, active, wd_exp;

   assign mem_req   = (st == S_SRC && !f_dir) || (st == S_DST && f_dir);
   assign mem_we    = (st == S_DST) && f_dir;
   assign mem_addr  = {f_ext, maddr};
   assign mem_be    = be_x;
   assign mem_wdata = wr_word;
   assign per_req   = (st == S_SRC && f_dir) || (st == S_DST && !f_dir);
   assign per_we    = (st == S_DST) && !f_dir;
   assign per_addr  = paddr;
   assign per_wdata = hold;

   assign src_gnt = f_dir ? per_gnt : mem_gnt;
   assign dst_gnt = f_dir ? mem_gnt : per_gnt;
   assign active  = (st == S_SRC) || (st == S_DST);

   dll_watchdog #(.WD_W(WD_W)) u_wd (
      .clk(clk), .rst_n(rst_n), .active(active),
      .gnt((st == S_SRC) ? src_gnt : dst_gnt),
      .limit(wd_limit), .expired(wd_exp)
   );

   always_comb begin
      case (st)
         S_IDLE:  status = STAT_IDLE;
         S_CPL:   status = STAT_CPL;
         S_TMO:   status = STAT_TMO;
         default: status = STAT_BUSY;
      endcase
   end

   logic last_row, last_all;
   assign last_row = (beats_left == 16'd1);
   assign last_all = last_row && (rows_left == 16'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; irq <= 1'b0; base <= '0; fcnt <= '0;
         maddr <= '0; paddr <= '0; hold <= '0; bcnt <= '0; dly <= '0;
         beats_left <= '0; rb_reload <= '0; rows_left <= '0;
      end else begin
         irq <= 1'b0;
         if (cancel) begin
            st <= S_IDLE;
         end else begin
            case (st)
               S_IDLE: if (start) begin
                  base <= start_ptr[IW+1:2];
                  fcnt <= '0;
                  st   <= S_FETCH;
               end
               S_FETCH: begin
                  fcnt <= fcnt + 1'b1;
                  if (fcnt == 3'd7) st <= S_SETUP;
               end
               S_SETUP: begin
                  maddr      <= dw[6];
                  paddr      <= dw[2];
                  bcnt       <= '0;
                  rows_left  <= rows_calc;
                  beats_left <= rb_calc;
                  rb_reload  <= rb_calc;
                  st <= (rows_calc == '0 || rb_calc == '0) ? S_NEXT : S_SRC;
               end
               S_SRC: begin
                  if (wd_exp) begin
                     st <= S_TMO; irq <= 1'b1;
                  end else if (src_gnt) begin
                     hold <= unit_x;
                     st   <= S_DST;
                  end
               end
               S_DST: begin
                  if (wd_exp) begin
                     st <= S_TMO; irq <= 1'b1;
                  end else if (dst_gnt) begin
                     paddr <= paddr + pstep_v;
                     maddr <= maddr + {29'd0, ub} + ((last_row && f_2d) ? {16'd0, f_gap} : 32'd0);
                     if (last_row) begin
                        rows_left  <= rows_left - 1'b1;
                        beats_left <= rb_reload;
                     end else begin
                        beats_left <= beats_left - 1'b1;
                     end
                     if (last_all) begin
                        st <= S_NEXT;
                     end else if (bcnt == f_burst) begin
                        bcnt <= '0;
                        if (f_dly != '0) begin
                           dly <= dly_load;
                           st  <= S_PAUSE;
                        end else begin
                           st <= S_SRC;
                        end
                     end else begin
                        bcnt <= bcnt + 1'b1;
                        st   <= S_SRC;
                     end
                  end
               end
               S_PAUSE: begin
                  if (dly == '0) st <= S_SRC;
                  else           dly <= dly - 1'b1;
               end
               S_NEXT: begin
                  if (stop_here) begin
                     st <= S_CPL; irq <= 1'b1;
                  end else begin
                     base <= link_byte[IW+1:2];
                     fcnt <= '0;
                     st   <= S_FETCH;
                  end
               end
               S_CPL, S_TMO: if (status_rd) st <= S_IDLE;
               default: st <= S_IDLE;
            endcase
         end
      end
   end

   logic unused_bits;
   assign unused_bits = ^{dw[0], dw[1], dw[3], dw[4], dw[5], dw[7], start_ptr, link_byte};

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status == STAT_IDLE) |-> (!mem_req && !per_req));
   // R3
   one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && per_req));
   // R8
   pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_PAUSE) |-> (!mem_req && !per_req));
   // R10
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status == STAT_CPL && !status_rd && !cancel) |=> (status == STAT_CPL));
   // R11
   wd_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_exp && !cancel) |=> (status == STAT_TMO));
   // R12
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R12
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status == STAT_CPL || status == STAT_TMO));
   // R13
   cancel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |=> (status == STAT_IDLE && !mem_req && !per_req));
endmodule

// File: tb/dll_dma_engine_tb.sv
module dll_dma_engine_tb;
   typedef struct {
      bit          is_mem;
      logic [35:0] addr;
      logic [31:0] data;
      logic [3:0]  be;
   } item_t;

   logic        clk = 0, rst_n = 0;
   logic        list_sys = 0, start = 0, status_rd = 0, cancel = 0;
   logic [31:0] start_ptr = 0;
   logic [15:0] wd_limit = 0;
   logic        dsc_we = 0;
   logic [5:0]  dsc_addr = 0;
   logic [31:0] dsc_wdata = 0;
   logic        mem_req, mem_we, per_req, per_we, irq;
   logic [35:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata, mem_rdata, per_addr, per_wdata, per_rdata;
   logic        mem_gnt, per_gnt, per_stall = 0;
   logic [1:0]  status;

   logic [31:0] mem [256];
   item_t       exp_q[$];
   int          wtimes[$];
   int          checks = 0, errors = 0, irq_cnt = 0, cyc = 0;
   string       cur_req = "R1";
   bit          done = 0;

   always #5 clk = ~clk;

   dll_dma_engine u_dut (
      .clk(clk), .rst_n(rst_n), .list_sys(list_sys), .start(start), .start_ptr(start_ptr),
      .status_rd(status_rd), .cancel(cancel), .wd_limit(wd_limit),
      .dsc_we(dsc_we), .dsc_addr(dsc_addr), .dsc_wdata(dsc_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
      .per_req(per_req), .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
      .per_rdata(per_rdata), .per_gnt(per_gnt), .status(status), .irq(irq)
   );

   function automatic logic [31:0] pdata(input logic [31:0] a);
      return {a[7:0] + 8'h44, a[7:0] + 8'h33, a[7:0] + 8'h22, a[7:0] + 8'h11};
   endfunction

   function automatic logic [31:0] rev(input logic [31:0] d, input int ub);
      if (ub == 4) return {d[7:0], d[15:8], d[23:16], d[31:24]};
      if (ub == 2) return {16'h0, d[7:0], d[15:8]};
      return d;
   endfunction

   // bench-side slave models
   assign mem_gnt   = 1'b1;
   assign per_gnt   = !per_stall;
   assign mem_rdata = mem[mem_addr[9:2]];
   assign per_rdata = pdata(per_addr);

   initial for (int i = 0; i < 256; i++)
      mem[i] = {8'(i) ^ 8'hA5, 8'(i) ^ 8'h3C, 8'(i), ~8'(i)};

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_req && mem_we && mem_gnt)
         for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[9:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   // monitor: compare every destination write with the scoreboard
   always @(negedge clk) begin
      if (rst_n && irq) irq_cnt++;
      if (rst_n && ((mem_req && mem_we && mem_gnt) || (per_req && per_we && per_gnt))) begin
         item_t it;
         wtimes.push_back(cyc);
         if (exp_q.size() == 0) begin
            check(0, cur_req, "unexpected write", {28'd0, mem_addr}, 0);
         end else begin
            it = exp_q.pop_front();
            if (it.is_mem) begin
               check(mem_req && mem_we, cur_req, "write port", {63'd0, mem_we}, 1);
               check(mem_addr == it.addr, cur_req, "mem addr", {28'd0, mem_addr}, {28'd0, it.addr});
               check(mem_be == it.be, cur_req, "mem be", {60'd0, mem_be}, {60'd0, it.be});
               check((mem_wdata & {{8{it.be[3]}}, {8{it.be[2]}}, {8{it.be[1]}}, {8{it.be[0]}}}) == it.data,
                     cur_req, "mem data", {32'd0, mem_wdata}, {32'd0, it.data});
            end else begin
               check(per_req && per_we, cur_req, "write port", {63'd0, per_we}, 1);
               check(per_addr == it.addr[31:0], cur_req, "per addr", {32'd0, per_addr}, {28'd0, it.addr});
               check(per_wdata == it.data, cur_req, "per data", {32'd0, per_wdata}, {32'd0, it.data});
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // driver: write one descriptor and push the writes it must produce
   task automatic put_desc(input int at, input bit dir, input int pw, input bit sw,
                           input bit pinc, input int pst, input int len, input int pa0,
                           input int dcode, input int burst, input int ext, input bit m2d,
                           input int rep, input int rowb, input int gap, input int sa,
                           input int link, input bit fin, input bit do_exp);
      logic [31:0] w [8];
      int ub, rows, rb, ma, pa, lane, step;
      logic [31:0] mask, raw, d;
      logic [3:0]  beb;
      w[0] = {28'd0, 2'(pw), dir, sw};
      w[1] = {16'(len), 13'd0, 2'(pst), pinc};
      w[2] = 32'(pa0);
      w[3] = {20'd0, 4'(ext), 1'b0, 3'(burst), 1'b0, 3'(dcode)};
      w[4] = {16'(rep), 15'd0, m2d};
      w[5] = {16'(gap), 16'(rowb)};
      w[6] = 32'(sa);
      w[7] = {fin, 3'b000, 28'(link)};
      for (int k = 0; k < 8; k++) begin
         dsc_we = 1; dsc_addr = 6'((at >> 2) + k); dsc_wdata = w[k];
         tick(1);
      end
      dsc_we = 0;
      if (!do_exp) return;
      ub   = (pw == 0) ? 4 : (pw == 1) ? 2 : 1;
      mask = (ub == 4) ? 32'hFFFF_FFFF : (ub == 2) ? 32'hFFFF : 32'hFF;
      beb  = (ub == 4) ? 4'hF : (ub == 2) ? 4'h3 : 4'h1;
      step = !pinc ? 0 : (pst == 0) ? 4 : (pst == 1) ? 2 : 1;
      rows = m2d ? rep : 1;
      rb   = m2d ? rowb / ub : len;
      ma = sa; pa = pa0;
      for (int r = 0; r < rows; r++) begin
         for (int b = 0; b < rb; b++) begin
            item_t it;
            lane = ma & 3;
            if (!dir) begin
               raw = (mem[(ma >> 2) & 255] >> (lane * 8)) & mask;
               d = sw ? rev(raw, ub) : raw;
               it.is_mem = 0; it.addr = 36'(pa); it.data = d; it.be = 0;
            end else begin
               raw = pdata(32'(pa)) & mask;
               d = sw ? rev(raw, ub) : raw;
               it.is_mem = 1; it.addr = {4'(ext), 32'(ma)};
               it.data = d << (lane * 8); it.be = beb << lane;
            end
            exp_q.push_back(it);
            pa += step; ma += ub;
         end
         if (m2d) ma += gap;
      end
   endtask

   task automatic go(input int p);
      start_ptr = 32'(p); start = 1; tick(1); start = 0;
   endtask

   task automatic wait_code(input logic [1:0] code, input int maxc);
      int n = 0;
      while (status != code && n < maxc) begin tick(1); n++; end
   endtask

   // wait for completion, check scoreboard drained, one irq, hold, acknowledge
   task automatic finish_chain(input string req);
      int irq0 = irq_cnt;
      wait_code(2'd2, 5000);
      check(status == 2'd2, "R10", {req, " completes"}, {62'd0, status}, 2);
      tick(4);
      check(exp_q.size() == 0, req, "all writes seen", 64'(exp_q.size()), 0);
      check(irq_cnt - irq0 == 1, "R12", "one irq per chain", 64'(irq_cnt - irq0), 1);
      check(status == 2'd2, "R10", "complete held", {62'd0, status}, 2);
      status_rd = 1; tick(1); status_rd = 0;
      check(status == 2'd0, "R10", "read returns idle", {62'd0, status}, 0);
   endtask

   initial begin
      tick(3);
      check(status == 0 && !mem_req && !per_req && !irq, "R1", "reset state",
            {60'd0, status, mem_req, per_req}, 0);
      rst_n = 1; tick(2);

      // R3 R6: 32-bit memory to peripheral, stepping by 4
      cur_req = "R3";
      put_desc(0, 0, 0, 0, 1, 0, 4, 'h1000, 0, 7, 0, 0, 0, 0, 0, 'h10, 0, 1, 1);
      go(0);
      finish_chain("R6");
      // R2: start while complete is ignored
      put_desc(0, 0, 0, 0, 1, 0, 1, 'h1000, 0, 0, 0, 0, 0, 0, 0, 'h10, 0, 1, 1);
      go(0);
      wait_code(2'd2, 500);
      go(0); tick(20);
      check(status == 2'd2, "R2", "start during complete ignored", {62'd0, status}, 2);
      check(exp_q.size() == 0, "R2", "no extra beats", 64'(exp_q.size()), 0);
      status_rd = 1; tick(1); status_rd = 0;

      // R4: bytes from odd lanes, step 1
      cur_req = "R4";
      put_desc(0, 0, 2, 1, 1, 2, 5, 'h2000, 0, 7, 0, 0, 0, 0, 0, 'h21, 0, 1, 1);
      go(0);
      finish_chain("R4");

      // R5 R14: peripheral to memory, 16-bit swapped, fixed address, ext bits
      cur_req = "R14";
      put_desc(0, 1, 1, 1, 0, 0, 3, 'h3000, 0, 7, 3, 0, 0, 0, 0, 'h202, 0, 1, 1);
      go(0);
      finish_chain("R5");

      // R7: 2D, 3 rows of 8 bytes, 8-byte gap, count field ignored
      cur_req = "R7";
      put_desc(0, 0, 0, 0, 1, 0, 99, 'h4000, 0, 7, 0, 1, 3, 8, 8, 'h40, 0, 1, 1);
      go(0);
      finish_chain("R7");

      // R9 local links, R2 start while busy
      cur_req = "R9";
      list_sys = 0;
      put_desc(0,    0, 0, 0, 1, 0, 2, 'h5100, 0, 7, 0, 0, 0, 0, 0, 'h80,  'h40, 0, 1);
      put_desc('h40, 1, 2, 0, 1, 2, 3, 'h5000, 0, 7, 0, 0, 0, 0, 0, 'h300, 0,    1, 1);
      go(0); tick(3);
      go('h40);
      check(status == 2'd1, "R2", "busy after second start", {62'd0, status}, 1);
      finish_chain("R9");

      // R9 system-memory links (shifted by 4)
      list_sys = 1;
      put_desc('h80, 0, 1, 0, 1, 1, 2, 'h5200, 0, 7, 0, 0, 0, 0, 0, 'h90, 'hC, 0, 1);
      put_desc('hC0, 0, 0, 0, 1, 0, 1, 'h5300, 0, 7, 0, 0, 0, 0, 0, 'hA0, 0,   1, 1);
      go('h80);
      finish_chain("R9");
      list_sys = 0;

      // R8: bursts of 2 with one delay step between them
      cur_req = "R8";
      put_desc(0, 0, 0, 0, 1, 0, 4, 'h6000, 1, 1, 0, 0, 0, 0, 0, 'h10, 0, 1, 1);
      wtimes.delete();
      go(0);
      finish_chain("R8");
      check(wtimes.size() == 4, "R8", "beat count", 64'(wtimes.size()), 4);
      if (wtimes.size() == 4) begin
         check(wtimes[1] - wtimes[0] == 2, "R8", "gap in burst", 64'(wtimes[1] - wtimes[0]), 2);
         check(wtimes[2] - wtimes[1] == 258, "R8", "gap after burst", 64'(wtimes[2] - wtimes[1]), 258);
         check(wtimes[3] - wtimes[2] == 2, "R8", "gap in burst", 64'(wtimes[3] - wtimes[2]), 2);
      end

      // R11 R12: stalled peripheral times out
      cur_req = "R11";
      begin
         int irq0;
         per_stall = 1; wd_limit = 20; irq0 = irq_cnt;
         put_desc(0, 0, 0, 0, 1, 0, 2, 'h7000, 0, 7, 0, 0, 0, 0, 0, 'h10, 0, 1, 0);
         go(0); tick(12);
         check(status == 2'd1, "R11", "busy before limit", {62'd0, status}, 1);
         wait_code(2'd3, 60);
         check(status == 2'd3, "R11", "timeout status", {62'd0, status}, 3);
         tick(2);
         check(irq_cnt - irq0 == 1, "R12", "irq on timeout", 64'(irq_cnt - irq0), 1);
         status_rd = 1; tick(1); status_rd = 0;
         check(status == 2'd0, "R10", "read clears timeout", {62'd0, status}, 0);
         per_stall = 0; wd_limit = 0;
      end

      // R13: cancel a stalled transfer
      cur_req = "R13";
      begin
         int irq0;
         per_stall = 1; irq0 = irq_cnt;
         put_desc(0, 0, 0, 0, 1, 0, 2, 'h7000, 0, 7, 0, 0, 0, 0, 0, 'h10, 0, 1, 0);
         go(0); tick(30);
         check(status == 2'd1, "R13", "busy while stalled", {62'd0, status}, 1);
         cancel = 1; tick(1); cancel = 0;
         check(status == 2'd0 && !mem_req && !per_req, "R13", "idle after cancel",
               {60'd0, status, mem_req, per_req}, 0);
         per_stall = 0; tick(10);
         check(status == 2'd0, "R13", "stays idle", {62'd0, status}, 0);
         check(irq_cnt == irq0, "R13", "no irq on cancel", 64'(irq_cnt), 64'(irq0));
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule